// File: doc/BRIEF.md
# Sixteen-bit event timer with capture, reload and baud-tick modes

This block is a 16-bit up-counter behind a small byte-wide register port. It counts either internal time (the core clock divided by a fixed prescale of 12) or falling edges on an external count pin. When the counter passes its all-ones value it can reload from a 16-bit reload register or wrap to zero. A second external pin, the trigger, can copy the live count into that same register (capture) or force a reload. An interrupt request follows two sticky flags: one for overflow, one for accepted trigger edges.

Two select bits turn the counter into a baud-rate source for a serial port. Each overflow then becomes a one-cycle receive tick, a transmit tick, or both. While either select bit is set, the counter always reloads on overflow, whatever the capture/reload choice says. In that state the overflow flag stays clear and trigger edges are ignored. Both pins pass through a two-flop synchroniser, and only their 1-to-0 transitions are acted on.

Top module: `evt_timer16`

## Requirements
- R1: After reset the control register, counter and reload register read 0, and `irq`, `rx_tick` and `tx_tick` are low.
- R2: Register map: address 0 control, 1/2 counter low/high byte, 3/4 reload low/high byte. `reg_rdata` shows the register addressed one cycle earlier. Control bits, from bit 7 down to bit 0: overflow flag, trigger flag, receive-tick select, transmit-tick select, trigger enable, run, external-count select, capture mode.
- R3: With run=1 and external-count select=0, the counter advances by exactly one per 12 clock cycles. With run=0 it holds its value.
- R4: With run=1 and external-count select=1, the counter advances once per synchronised falling edge of `cnt_pin`.
- R5: In reload mode (capture mode=0, both tick selects 0), an advance from 0xFFFF loads the reload register and sets the overflow flag.
- R6: In capture mode (capture mode=1, both tick selects 0), an advance from 0xFFFF wraps the counter to 0 and sets the overflow flag. The reload register is unchanged.
- R7: With trigger enable=1 and capture mode=1, a falling edge on `trig_pin` copies the counter into the reload register and sets the trigger flag. The counter is unaffected.
- R8: With trigger enable=1 and capture mode=0, a falling edge on `trig_pin` loads the counter from the reload register and sets the trigger flag.
- R9: With trigger enable=0, edges on `trig_pin` change neither register nor either flag.
- R10: While either tick select is 1, overflow always reloads the counter, the overflow flag is never set, and trigger edges are ignored. Each overflow pulses `rx_tick` for one cycle if receive select is 1, and `tx_tick` for one cycle if transmit select is 1.
- R11: `irq` is high exactly while either flag is 1. The flags stay set until the control register is written. Writing 1 or 0 to a flag bit sets or clears it.
- R12: When an overflow and an accepted trigger edge fall in the same cycle, both flags are set. In capture mode the reload register receives 0xFFFF and the counter goes to 0. In reload mode the counter takes the reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data of the previous cycle's address |
| cnt_pin | input | 1 | External count pin, asynchronous |
| trig_pin | input | 1 | External trigger pin, asynchronous |
| irq | output | 1 | Interrupt request, OR of the two flags |
| rx_tick | output | 1 | Receive baud tick, one cycle per overflow |
| tx_tick | output | 1 | Transmit baud tick, one cycle per overflow |

## Verification
An overflow and an accepted trigger edge can land in the same cycle, and the two ask different things of the counter and the reload register. The bench provokes this deterministically. It selects external counting, presets the counter to 0xFFFF, and drops `cnt_pin` and `trig_pin` on the same clock edge, so both synchronisers report their edges together. Readback of the control, counter and reload registers is then compared with the values R12 predicts, once in capture mode and once in reload mode.

// File: rtl/etm_pkg.sv
package etm_pkg;

  typedef struct packed {
    logic ovf_flag;
    logic ext_flag;
    logic rx_sel;
    logic tx_sel;
    logic ext_en;
    logic run;
    logic ext_clk;
    logic cap_mode;
  } etm_ctrl_t;

  localparam int unsigned CTRL_ADDR = 0;
  localparam int unsigned CNT_BASE  = 1;

endpackage

// File: rtl/etm_edge_sync.sv
module etm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic fall
);

  // STAGES synchroniser flops followed by one history flop
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '1;
    else     sh_q <= {sh_q[STAGES-1:0], pin};
  end

  assign fall = sh_q[STAGES] & ~sh_q[STAGES-1];

endmodule

// File: rtl/etm_prescaler.sv
module etm_prescaler #(
  parameter int DIV = 12,
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);

  logic [PW-1:0] pre_q;

  assign tick = (pre_q == PW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst)       pre_q <= '0;
    else if (tick) pre_q <= '0;
    else           pre_q <= pre_q + 1'b1;
  end

endmodule

// File: rtl/etm_count_core.sv
module etm_count_core #(
  parameter int CW = 16,
  localparam int NB = CW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          trig_fall,
  input  logic          ext_en,
  input  logic          cap_mode,
  input  logic          baud,
  input  logic [NB-1:0] cnt_we,
  input  logic [NB-1:0] rld_we,
  input  logic [7:0]    wdata,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] rld,
  output logic          ovf_evt,
  output logic          trig_evt
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] rld_q, rld_d;
  logic          at_max;
  logic          do_capture;

  always_comb begin
    at_max     = (cnt_q == {CW{1'b1}});
    ovf_evt    = inc && at_max;
    trig_evt   = trig_fall && ext_en && !baud;
    do_capture = trig_evt && cap_mode;

    cnt_d = cnt_q;
    rld_d = rld_q;

    if (inc) begin
      if (!at_max)                cnt_d = cnt_q + 1'b1;
      else if (baud || !cap_mode) cnt_d = rld_q;
      else                        cnt_d = '0;
    end
    if (trig_evt && !cap_mode) cnt_d = rld_q;

    for (int b = 0; b < NB; b++) begin
      if (cnt_we[b]) cnt_d[b*8 +: 8] = wdata;
      if (rld_we[b]) rld_d[b*8 +: 8] = wdata;
    end
    // a capture wins over a same-cycle software write of the reload bytes
    if (do_capture) rld_d = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      rld_q <= rld_d;
    end
  end

  assign cnt = cnt_q;
  assign rld = rld_q;

endmodule

// File: rtl/evt_timer16.sv
module evt_timer16 #(
  parameter int CW          = 16,
  parameter int PRESCALE    = 12,
  parameter int SYNC_STAGES = 2,
  parameter int AW          = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          cnt_pin,
  input  logic          trig_pin,
  output logic          irq,
  output logic          rx_tick,
  output logic          tx_tick
);

  import etm_pkg::*;

  localparam int NB       = CW / 8;
  localparam int RLD_BASE = CNT_BASE + NB;

  etm_ctrl_t     ctrl_q, ctrl_d;
  logic          ctrl_we;
  logic [NB-1:0] cnt_we, rld_we;
  logic          cnt_fall, trig_fall, pre_tick;
  logic          baud, inc;
  logic          ovf_evt, trig_evt;
  logic [CW-1:0] cnt, rld;
  logic [7:0]    rdata_d;

  etm_edge_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
    .clk(clk), .rst(rst), .pin(cnt_pin), .fall(cnt_fall)
  );

  etm_edge_sync #(.STAGES(SYNC_STAGES)) u_trig_sync (
    .clk(clk), .rst(rst), .pin(trig_pin), .fall(trig_fall)
  );

  etm_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst(rst), .tick(pre_tick)
  );

  assign ctrl_we = reg_wr && (reg_addr == AW'(CTRL_ADDR));

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign cnt_we[b] = reg_wr && (reg_addr == AW'(CNT_BASE + b));
    assign rld_we[b] = reg_wr && (reg_addr == AW'(RLD_BASE + b));
  end

  assign baud = ctrl_q.rx_sel | ctrl_q.tx_sel;
  assign inc  = ctrl_q.run && (ctrl_q.ext_clk ? cnt_fall : pre_tick);

  etm_count_core #(.CW(CW)) u_core (
    .clk(clk), .rst(rst), .inc(inc), .trig_fall(trig_fall),
    .ext_en(ctrl_q.ext_en), .cap_mode(ctrl_q.cap_mode), .baud(baud),
    .cnt_we(cnt_we), .rld_we(rld_we), .wdata(reg_wdata),
    .cnt(cnt), .rld(rld), .ovf_evt(ovf_evt), .trig_evt(trig_evt)
  );

  // control register: hardware flag set beats a same-cycle software write
  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we) ctrl_d = etm_ctrl_t'(reg_wdata);
    if (ovf_evt && !baud) ctrl_d.ovf_flag = 1'b1;
    if (trig_evt)         ctrl_d.ext_flag = 1'b1;
  end

  always_comb begin
    rdata_d = '0;
    if (reg_addr == AW'(CTRL_ADDR)) rdata_d = ctrl_q;
    for (int b = 0; b < NB; b++) begin
      if (reg_addr == AW'(CNT_BASE + b)) rdata_d = cnt[b*8 +: 8];
      if (reg_addr == AW'(RLD_BASE + b)) rdata_d = rld[b*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      reg_rdata <= '0;
      rx_tick   <= 1'b0;
      tx_tick   <= 1'b0;
    end else begin
      ctrl_q    <= ctrl_d;
      reg_rdata <= rdata_d;
      rx_tick   <= ovf_evt && ctrl_q.rx_sel;
      tx_tick   <= ovf_evt && ctrl_q.tx_sel;
    end
  end

  assign irq = ctrl_q.ovf_flag | ctrl_q.ext_flag;

endmodule

// File: rtl/etm_checker.sv
module etm_checker #(
  parameter int CW = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input etm_pkg::etm_ctrl_t ctrl,
  input logic              trig_evt,
  input logic [CW-1:0]     cnt,
  input logic [CW-1:0]     rld,
  input logic              rx_tick,
  input logic              tx_tick
);

  logic baud_on;
  assign baud_on = ctrl.rx_sel | ctrl.tx_sel;

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.run && !reg_wr && !trig_evt) |=> $stable(cnt)); // R3

  AST_RELOAD_REG_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!reg_wr && !trig_evt) |=> $stable(rld)); // R7

  AST_BAUD_NO_OVF_FLAG: assert property (@(posedge clk) disable iff (rst)
    (baud_on && !reg_wr && !ctrl.ovf_flag) |=> !ctrl.ovf_flag); // R10

  AST_BAUD_NO_EXT_FLAG: assert property (@(posedge clk) disable iff (rst)
    (baud_on && !reg_wr && !ctrl.ext_flag) |=> !ctrl.ext_flag); // R10

  AST_RX_TICK_SEL: assert property (@(posedge clk) disable iff (rst)
    rx_tick |-> $past(ctrl.rx_sel)); // R10

  AST_TX_TICK_SEL: assert property (@(posedge clk) disable iff (rst)
    tx_tick |-> $past(ctrl.tx_sel)); // R10

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ctrl.ovf_flag && !reg_wr) |=> ctrl.ovf_flag); // R11

endmodule

bind evt_timer16 etm_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .ctrl(ctrl_q),
  .trig_evt(trig_evt), .cnt(cnt), .rld(rld),
  .rx_tick(rx_tick), .tx_tick(tx_tick)
);

// File: tb/sim_evt_timer16.sv
module sim_evt_timer16;

  localparam int CLK_PERIOD = 10;
  localparam int PRE = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       cnt_pin = 1'b1;
  logic       trig_pin = 1'b1;
  logic       irq, rx_tick, tx_tick;

  evt_timer16 u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_pin(cnt_pin),
    .trig_pin(trig_pin), .irq(irq), .rx_tick(rx_tick), .tx_tick(tx_tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int         kind;   // 0: reg_rdata, 1: irq
    logic [7:0] exp;
    int         due;
    string      tag;
  } sb_item_t;

  sb_item_t sbq[$];
  sb_item_t cur;
  int cyc = 0;
  int total = 0;
  int bad = 0;
  int rxc = 0;
  int txc = 0;
  bit done = 0;
  logic [7:0] act;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rx_tick) rxc++;
    if (tx_tick) txc++;
  end

  // monitor: compare queued expectations when they fall due
  always @(negedge clk) begin
    while (sbq.size() > 0 && cyc >= sbq[0].due) begin
      cur = sbq.pop_front();
      act = (cur.kind == 0) ? reg_rdata : {7'b0, irq};
      total++;
      if (act !== cur.exp) begin
        bad++;
        $display("FAIL %s actual=%h expected=%h", cur.tag, act, cur.exp);
      end
    end
  end

  task automatic check(input int a, input int e, input string tag);
    total++;
    if (a != e) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, a, e);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wr16(input logic [2:0] a, input logic [15:0] d);
    wr(a, d[7:0]);
    wr(a + 3'd1, d[15:8]);
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    reg_addr = a;
    sbq.push_back('{0, e, cyc + 1, tag});
    @(negedge clk);
  endtask

  task automatic rd16(input logic [2:0] a, input logic [15:0] e, input string tag);
    rd(a, e[7:0], tag);
    rd(a + 3'd1, e[15:8], tag);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    sbq.push_back('{1, {7'b0, e}, cyc + 1, tag});
    @(negedge clk);
  endtask

  task automatic trig_pulse();
    trig_pin = 1'b0; repeat (4) @(negedge clk);
    trig_pin = 1'b1; repeat (4) @(negedge clk);
  endtask

  task automatic cnt_pulse();
    cnt_pin = 1'b0; repeat (4) @(negedge clk);
    cnt_pin = 1'b1; repeat (4) @(negedge clk);
  endtask

  task automatic both_pulse();
    cnt_pin = 1'b0; trig_pin = 1'b0; repeat (4) @(negedge clk);
    cnt_pin = 1'b1; trig_pin = 1'b1; repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, 8'h00, "R1 ctrl");
    rd16(3'd1, 16'h0000, "R1 count");
    rd16(3'd3, 16'h0000, "R1 reload");
    chk_irq(1'b0, "R1 irq");
    check(rxc + txc, 0, "R1 ticks");

    // R2 R3 timer mode: 5 periods of 12 cycles
    wr16(3'd1, 16'h1234);
    wr(3'd0, 8'h04);
    repeat (PRE*5 - 1) @(negedge clk);
    wr(3'd0, 8'h00);
    rd16(3'd1, 16'h1239, "R3 timer advance");
    repeat (30) @(negedge clk);
    rd16(3'd1, 16'h1239, "R3 stopped holds");

    // R4 external counting
    wr16(3'd1, 16'h0010);
    wr(3'd0, 8'h06);
    repeat (3) cnt_pulse();
    repeat (4) @(negedge clk);
    wr(3'd0, 8'h00);
    rd16(3'd1, 16'h0013, "R4 edge count");

    // R5 overflow in reload mode
    wr16(3'd3, 16'hFF00);
    wr16(3'd1, 16'hFFFE);
    wr(3'd0, 8'h04);
    repeat (PRE*2 - 1) @(negedge clk);
    wr(3'd0, 8'h80);
    rd16(3'd1, 16'hFF00, "R5 reload on overflow");
    rd(3'd0, 8'h80, "R5 overflow flag");
    chk_irq(1'b1, "R11 irq on overflow flag");
    wr(3'd0, 8'h00);
    chk_irq(1'b0, "R11 irq cleared");
    rd(3'd0, 8'h00, "R11 flag cleared");

    // R6 overflow in capture mode
    wr16(3'd3, 16'h4444);
    wr16(3'd1, 16'hFFFE);
    wr(3'd0, 8'h05);
    repeat (PRE*2 - 1) @(negedge clk);
    wr(3'd0, 8'h81);
    rd16(3'd1, 16'h0000, "R6 wrap to zero");
    rd16(3'd3, 16'h4444, "R6 reload untouched");
    rd(3'd0, 8'h81, "R6 overflow flag");
    wr(3'd0, 8'h00);

    // R7 capture on trigger
    wr16(3'd1, 16'hABCD);
    wr(3'd0, 8'h09);
    trig_pulse();
    rd16(3'd3, 16'hABCD, "R7 captured count");
    rd16(3'd1, 16'hABCD, "R7 counter unaffected");
    rd(3'd0, 8'h49, "R7 trigger flag");
    chk_irq(1'b1, "R11 irq on trigger flag");
    wr(3'd0, 8'h00);

    // R9 trigger disabled
    wr16(3'd3, 16'h1111);
    wr(3'd0, 8'h01);
    trig_pulse();
    rd16(3'd3, 16'h1111, "R9 no capture");
    rd(3'd0, 8'h01, "R9 no flag");
    wr16(3'd1, 16'h0002);
    wr(3'd0, 8'h00);
    trig_pulse();
    rd16(3'd1, 16'h0002, "R9 no reload");
    chk_irq(1'b0, "R9 irq low");

    // R8 reload on trigger
    wr16(3'd3, 16'h5A5A);
    wr16(3'd1, 16'h0001);
    wr(3'd0, 8'h08);
    trig_pulse();
    rd16(3'd1, 16'h5A5A, "R8 trigger reload");
    rd(3'd0, 8'h48, "R8 trigger flag");
    wr(3'd0, 8'h00);

    // R10 receive ticks: 32 increments from 0xFFF0 -> two overflows
    wr16(3'd3, 16'hFFF0);
    wr16(3'd1, 16'hFFF0);
    rxc = 0; txc = 0;
    wr(3'd0, 8'h2D);
    repeat (PRE*32 - 1) @(negedge clk);
    wr(3'd0, 8'h29);
    trig_pulse();
    rd16(3'd1, 16'hFFF0, "R10 reload despite capture mode");
    rd16(3'd3, 16'hFFF0, "R10 trigger ignored");
    rd(3'd0, 8'h29, "R10 no flags in baud mode");
    check(rxc, 2, "R10 rx tick count");
    check(txc, 0, "R10 tx quiet");

    // R10 transmit tick
    wr16(3'd1, 16'hFFFF);
    rxc = 0; txc = 0;
    wr(3'd0, 8'h14);
    repeat (PRE - 1) @(negedge clk);
    wr(3'd0, 8'h10);
    repeat (2) @(negedge clk);
    check(txc, 1, "R10 tx tick count");
    check(rxc, 0, "R10 rx quiet");
    rd16(3'd1, 16'hFFF0, "R10 tx reload");
    rd(3'd0, 8'h10, "R10 tx no flag");
    wr(3'd0, 8'h00);

    // R12 collision in capture mode
    wr16(3'd3, 16'h0000);
    wr16(3'd1, 16'hFFFF);
    wr(3'd0, 8'h0F);
    both_pulse();
    rd(3'd0, 8'hCF, "R12 both flags capture");
    rd16(3'd1, 16'h0000, "R12 counter wrapped");
    rd16(3'd3, 16'hFFFF, "R12 captured all-ones");
    wr(3'd0, 8'h00);

    // R12 collision in reload mode
    wr16(3'd3, 16'h3000);
    wr16(3'd1, 16'hFFFF);
    wr(3'd0, 8'h0E);
    both_pulse();
    rd(3'd0, 8'hCE, "R12 both flags reload");
    rd16(3'd1, 16'h3000, "R12 reloaded");
    wr(3'd0, 8'h00);

    // R11 software-set flag
    wr(3'd0, 8'h40);
    chk_irq(1'b1, "R11 software set");
    rd(3'd0, 8'h40, "R11 flag readback");
    wr(3'd0, 8'h00);
    chk_irq(1'b0, "R11 software clear");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule